// File: doc/BRIEF.md
# Single-Source Interrupt Sequencer

This block decides when a program-sequencing core takes its one external interrupt, and it steers the program counter when that happens. An active-low request line is watched for a high-to-low transition that then stays low for a minimum number of instruction cycles. Once such a pulse qualifies, a pending flag is latched. The flag waits until the interrupt-enable bit is set and the core reports that the current instruction is complete.

At that point the sequencer takes the interrupt. It pushes the address of the next sequential instruction onto a small hardware return stack, and when the stack is full the oldest entry falls off the bottom. It loads a fixed vector into the program counter and clears the enable bit, so the interrupt cannot nest. Instruction fetch and decode lie outside the block. They are represented by an increment request, a return (pop) request, an instruction-complete flag, and set/clear strobes for the enable bit.

Each clock edge is one instruction cycle. The request line is taken as already synchronous to the clock.

Top module: `irq_seq_top`

## Requirements
- R1: While `rst_n` is low and after its release, `pc_o` is 0, `irq_en_o` is 0 and `irq_pend_o` is 0 until stimulus changes them.
- R2: A pending interrupt is raised only if `irq_n` is sampled high on one clock edge and then low on at least MIN_LOW (2) consecutive edges. A low that lasts one edge raises nothing. A low already present when reset is released raises nothing. A low of any length raises at most one pending interrupt.
- R3: `irq_pend_o` rises on the clock edge that follows the second consecutive low sample. Without a take, it stays high indefinitely.
- R4: `irq_ack_o` is high in a cycle exactly when `irq_pend_o`, `irq_en_o` and `instr_done` are all 1, and the interrupt is then taken on that clock edge.
- R5: On a take, `pc_o` becomes the vector 0x0FF.
- R6: On a take, `pc_o + 1` (modulo 1024) is pushed onto the return stack, so a following `ret_pop` reloads exactly that address.
- R7: The return stack holds 3 entries. A push onto a full stack discards the oldest entry.
- R8: A take clears `irq_en_o`, and this overrides an `en_set` in the same cycle. `en_clr` overrides `en_set`, and `en_set` alone sets the bit on the next edge.
- R9: A take clears `irq_pend_o`.
- R10: `ret_pop` loads the top stack entry into `pc_o` and moves every entry up one level. The bottom level keeps its value, so repeated pops past the depth keep returning the oldest surviving entry.
- R11: Without a take or `ret_pop`, `pc_inc` adds 1 to `pc_o` modulo 1024, and with none of the three `pc_o` holds. The priority is take, then `ret_pop`, then `pc_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Active-low interrupt request line |
| instr_done | input | 1 | Current instruction has completed |
| pc_inc | input | 1 | Advance program counter by one |
| ret_pop | input | 1 | Return: pop top stack entry into the program counter |
| en_set | input | 1 | Set the interrupt-enable bit |
| en_clr | input | 1 | Clear the interrupt-enable bit |
| pc_o | output | 10 | Program counter |
| irq_en_o | output | 1 | Interrupt-enable bit |
| irq_pend_o | output | 1 | Latched pending interrupt |
| irq_ack_o | output | 1 | Interrupt is being taken this cycle |

## Verification
The hardest case to reach is a full return stack that overflows, followed by pops beyond its depth. The bench reaches it by chaining four interrupts. Before each one it re-enables the interrupt and advances the counter by a different amount, so that every pushed address is distinct and the lost entry can be identified. Two further cases need exact alignment in one cycle: a take that coincides with set, pop and increment requests, and a push from the top address that wraps to zero. The bench reaches the wrap by stepping the counter 1023 times.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [1:0] {
      PC_HOLD = 2'd0,
      PC_INC  = 2'd1,
      PC_POP  = 2'd2,
      PC_VEC  = 2'd3
   } pc_sel_e;
endpackage

// File: rtl/irq_seq_qual.sv
module irq_seq_qual #(
   parameter int MIN_LOW = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_n,
   output logic qual_o
);
   logic armed;

   if (MIN_LOW < 1) begin : g_bad
      $error("irq_seq_qual: MIN_LOW must be at least 1");
   end

   if (MIN_LOW == 1) begin : g_edge
      // any sampled high-to-low step qualifies at once
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            armed  <= 1'b0;
            qual_o <= 1'b0;
         end else begin
            armed  <= irq_n;
            qual_o <= armed & ~irq_n;
         end
      end
   end else begin : g_count
      localparam int CNT_W = $clog2(MIN_LOW);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LOW - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            armed  <= 1'b0;
            cnt    <= '0;
            qual_o <= 1'b0;
         end else begin
            qual_o <= 1'b0;
            if (irq_n) begin
               armed <= 1'b1;
               cnt   <= '0;
            end else if (armed) begin
               if (cnt == LAST) begin
                  qual_o <= 1'b1;
                  armed  <= 1'b0;
                  cnt    <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/irq_seq_stack.sv
module irq_seq_stack #(
   parameter int W     = 10,
   parameter int DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] top_o
);
   if (DEPTH < 1) begin : g_bad
      $error("irq_seq_stack: DEPTH must be at least 1");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      logic [W-1:0] q;
      logic [W-1:0] from_up;
      logic [W-1:0] from_dn;

      if (i == 0) begin : g_first
         assign from_up = din;
      end else begin : g_mid_up
         assign from_up = g_lvl[i-1].q;
      end

      if (i == DEPTH - 1) begin : g_last
         assign from_dn = q;
      end else begin : g_mid_dn
         assign from_dn = g_lvl[i+1].q;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)    q <= '0;
         else if (push) q <= from_up;
         else if (pop)  q <= from_dn;
      end
   end

   assign top_o = g_lvl[0].q;
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top #(
   parameter int          PC_W    = 10,
   parameter int          DEPTH   = 3,
   parameter int          MIN_LOW = 2,
   parameter logic [9:0]  VEC     = 10'h0FF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_n,
   input  logic            instr_done,
   input  logic            pc_inc,
   input  logic            ret_pop,
   input  logic            en_set,
   input  logic            en_clr,
   output logic [PC_W-1:0] pc_o,
   output logic            irq_en_o,
   output logic            irq_pend_o,
   output logic            irq_ack_o
);
   import irq_seq_pkg::*;

   localparam logic [PC_W-1:0] VEC_PC = PC_W'(VEC);

   if (PC_W < 10) begin : g_bad_w
      $error("irq_seq_top: PC_W too narrow for the vector");
   end

   logic            qual;
   logic            take;
   logic [PC_W-1:0] pc_plus;
   logic [PC_W-1:0] stk_top;
   logic [PC_W-1:0] pc_nxt;
   pc_sel_e         sel;

   irq_seq_qual #(.MIN_LOW(MIN_LOW)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_n  (irq_n),
      .qual_o (qual)
   );

   assign take    = irq_pend_o & irq_en_o & instr_done;
   assign pc_plus = pc_o + 1'b1;

   irq_seq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (take),
      .pop   (ret_pop & ~take),
      .din   (pc_plus),
      .top_o (stk_top)
   );

   always_comb begin
      if (take)         sel = PC_VEC;
      else if (ret_pop) sel = PC_POP;
      else if (pc_inc)  sel = PC_INC;
      else              sel = PC_HOLD;
   end

   always_comb begin
      unique case (sel)
         PC_VEC:  pc_nxt = VEC_PC;
         PC_POP:  pc_nxt = stk_top;
         PC_INC:  pc_nxt = pc_plus;
         default: pc_nxt = pc_o;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_o       <= '0;
         irq_en_o   <= 1'b0;
         irq_pend_o <= 1'b0;
      end else begin
         pc_o       <= pc_nxt;
         irq_pend_o <= qual | (irq_pend_o & ~take);
         if (take || en_clr) irq_en_o <= 1'b0;
         else if (en_set)    irq_en_o <= 1'b1;
      end
   end

   assign irq_ack_o = take;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int         PC_W = 10,
   parameter logic [9:0] VEC  = 10'h0FF
) (
   input logic            clk,
   input logic            rst_n,
   input logic            instr_done,
   input logic            pc_inc,
   input logic            ret_pop,
   input logic            en_set,
   input logic            en_clr,
   input logic [PC_W-1:0] pc_o,
   input logic            irq_en_o,
   input logic            irq_pend_o,
   input logic            irq_ack_o
);
   a_r4_ack_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_o |-> (irq_en_o && irq_pend_o && instr_done));

   a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_o |=> (pc_o == PC_W'(VEC)));

   a_r8_self_disable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_o |=> !irq_en_o);

   a_r8_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |=> !irq_en_o);

   a_r3_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend_o && !irq_ack_o) |=> irq_pend_o);

   a_r11_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_inc && !ret_pop && !irq_ack_o) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_inc && !ret_pop && !irq_ack_o) |=> $stable(pc_o));

   a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
      (en_set && !en_clr && !irq_ack_o) |=> irq_en_o);
endmodule

bind irq_seq_top irq_seq_chk #(.PC_W(PC_W), .VEC(VEC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .instr_done (instr_done),
   .pc_inc     (pc_inc),
   .ret_pop    (ret_pop),
   .en_set     (en_set),
   .en_clr     (en_clr),
   .pc_o       (pc_o),
   .irq_en_o   (irq_en_o),
   .irq_pend_o (irq_pend_o),
   .irq_ack_o  (irq_ack_o)
);

// File: tb/irq_seq_top_tb.sv
module irq_seq_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       irq_n = 1'b1;
   logic       instr_done = 1'b0;
   logic       pc_inc = 1'b0;
   logic       ret_pop = 1'b0;
   logic       en_set = 1'b0;
   logic       en_clr = 1'b0;
   logic [9:0] pc_o;
   logic       irq_en_o;
   logic       irq_pend_o;
   logic       irq_ack_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   irq_seq_top u_dut (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .instr_done(instr_done),
      .pc_inc(pc_inc), .ret_pop(ret_pop), .en_set(en_set), .en_clr(en_clr),
      .pc_o(pc_o), .irq_en_o(irq_en_o), .irq_pend_o(irq_pend_o),
      .irq_ack_o(irq_ack_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_n = 1'b1; instr_done = 1'b0; pc_inc = 1'b0;
      ret_pop = 1'b0; en_set = 1'b0; en_clr = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic enable();
      en_set = 1'b1; tick(); en_set = 1'b0;
   endtask

   task automatic incs(input int n);
      pc_inc = 1'b1; repeat (n) tick(); pc_inc = 1'b0;
   endtask

   task automatic pulse(input int w);
      irq_n = 1'b0; repeat (w) tick(); irq_n = 1'b1;
   endtask

   // enable, qualify a 2-cycle pulse, take it with instr_done high
   task automatic fire();
      instr_done = 1'b1;
      enable();
      pulse(2);
      tick(); tick();
      chk("R5 vector after take", int'(pc_o), 'h0FF);
      chk("R8 enable cleared by take", int'(irq_en_o), 0);
   endtask

   task automatic pop_chk(input int exp, input string tag);
      ret_pop = 1'b1; tick(); ret_pop = 1'b0;
      chk(tag, int'(pc_o), exp);
   endtask

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      chk("R1 pc after reset", int'(pc_o), 0);
      chk("R1 enable after reset", int'(irq_en_o), 0);
      chk("R1 pending after reset", int'(irq_pend_o), 0);
      chk("R1 ack after reset", int'(irq_ack_o), 0);

      // R2/R3/R4 sweep: pulse width x enable state, instr_done held low first
      for (int w = 1; w <= 5; w++) begin
         for (int e = 0; e <= 1; e++) begin
            bit q;
            q = (w >= 2);
            do_reset();
            if (e == 1) enable();
            pulse(w);
            tick(); tick();
            chk($sformatf("R2 pending w=%0d e=%0d", w, e), int'(irq_pend_o), int'(q));
            chk($sformatf("R4 no take without done w=%0d", w), int'(pc_o), 0);
            instr_done = 1'b1;
            #1;
            chk($sformatf("R4 ack w=%0d e=%0d", w, e), int'(irq_ack_o), int'(q && e == 1));
            tick();
            chk($sformatf("R5 pc w=%0d e=%0d", w, e), int'(pc_o), (q && e == 1) ? 'h0FF : 0);
            chk($sformatf("R9 pending w=%0d e=%0d", w, e), int'(irq_pend_o), int'(q && e == 0));
            chk($sformatf("R8 enable w=%0d e=%0d", w, e), int'(irq_en_o), (q && e == 1) ? 0 : e);
            if (q && e == 0) begin
               enable();
               chk("R4 late enable takes next", int'(irq_ack_o), 1);
               tick();
               chk("R5 late enable vector", int'(pc_o), 'h0FF);
               chk("R9 late enable clears pending", int'(irq_pend_o), 0);
            end
            instr_done = 1'b0;
         end
      end

      // R3 exact timing
      do_reset();
      enable();
      irq_n = 1'b0; tick(); tick();
      chk("R3 not pending after 2nd low sample", int'(irq_pend_o), 0);
      irq_n = 1'b1; tick();
      chk("R3 pending one edge later", int'(irq_pend_o), 1);
      repeat (6) tick();
      chk("R3 pending held without done", int'(irq_pend_o), 1);
      instr_done = 1'b1; #1;
      chk("R4 ack with all three", int'(irq_ack_o), 1);
      tick();
      chk("R5 vector", int'(pc_o), 'h0FF);
      chk("R4 ack drops after take", int'(irq_ack_o), 0);
      instr_done = 1'b0;

      // R2 low held across reset release
      rst_n = 1'b0; irq_n = 1'b0; tick(); tick(); rst_n = 1'b1;
      instr_done = 1'b1; enable();
      repeat (5) tick();
      chk("R2 low from reset ignored pend", int'(irq_pend_o), 0);
      chk("R2 low from reset ignored pc", int'(pc_o), 0);
      irq_n = 1'b1; tick();

      // R2 long low qualifies once
      do_reset();
      instr_done = 1'b1; enable();
      pulse(9);
      tick();
      chk("R2 long low one take pc", int'(pc_o), 'h0FF);
      chk("R2 long low no second pending", int'(irq_pend_o), 0);
      instr_done = 1'b0;

      // R6 push of pc+1 and return
      do_reset();
      incs(5);
      chk("R11 increment", int'(pc_o), 5);
      fire();
      pop_chk(6, "R6 return to pc+1");

      // R7/R10 overflow and pops past depth
      do_reset();
      incs(5);
      fire();
      incs(1); fire();
      incs(2); fire();
      incs(3); fire();
      pop_chk('h103, "R7 pop 1");
      pop_chk('h102, "R7 pop 2");
      pop_chk('h101, "R7 pop 3 oldest lost");
      pop_chk('h101, "R10 pop past depth keeps bottom");
      pop_chk('h101, "R10 pop past depth again");

      // R11/R6 wrap
      do_reset();
      incs(1023);
      chk("R11 reach top", int'(pc_o), 'h3FF);
      incs(1);
      chk("R11 wrap to zero", int'(pc_o), 0);
      incs(1023);
      fire();
      pop_chk(0, "R6 pushed address wraps");

      // R8/R11 priority in the take cycle
      do_reset();
      instr_done = 1'b1; enable();
      pulse(2); tick();
      en_set = 1'b1; ret_pop = 1'b1; pc_inc = 1'b1;
      tick();
      en_set = 1'b0; ret_pop = 1'b0; pc_inc = 1'b0;
      chk("R11 take beats pop and inc", int'(pc_o), 'h0FF);
      chk("R8 take beats en_set", int'(irq_en_o), 0);
      instr_done = 1'b0;
      pop_chk(1, "R6 push happened in take cycle");

      // R8 clear vs set
      en_set = 1'b1; en_clr = 1'b1; tick();
      en_set = 1'b0; en_clr = 1'b0;
      chk("R8 clear beats set", int'(irq_en_o), 0);
      enable();
      chk("R8 set alone", int'(irq_en_o), 1);
      en_clr = 1'b1; tick(); en_clr = 1'b0;
      chk("R8 clear alone", int'(irq_en_o), 0);

      // R11 hold
      repeat (3) tick();
      chk("R11 hold", int'(pc_o), 1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule